// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets two processors ring doorbells at each other through shared status words. There are three independent channels, ranked as low priority, high priority and secure. Each channel holds one 32-bit word for each direction of traffic. The sender raises bits by writing a mask to a set register, and those bits are ORed into the word. The receiver clears bits by writing a mask to a clear register. A receive interrupt for that channel stays high as long as the receiver's incoming word has any bit set.

Two APB-style register ports reach the same storage. The local port's transmit word for a channel is the remote port's receive word for that channel, and the reverse is also true. A message is complete once the receiver has cleared every bit, and the sender finds this out by reading its own transmit word back as zero. Both ports are always ready, so a write takes effect at the clock edge that ends its access phase. Each port can also read a fixed 24-bit identification value one byte at a time.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every status word reads as zero and all six interrupt outputs are low.
- R2: A write to a set register ORs the written value into the addressed word. Bits already pending stay pending.
- R3: A write to a clear register zeroes exactly the bits that are 1 in the written value. All other bits are left unchanged.
- R4: `loc_irq[c]` is high exactly when the word that the remote side sends on channel c is nonzero. `rem_irq[c]` is high exactly when the word that the local side sends on channel c is nonzero. Each channel drives its own line.
- R5: A port's transmit word on channel c and the other port's receive word on channel c are the same storage. A set or clear through either port is visible through both ports.
- R6: The byte addresses of the receive windows are 0x000 for channel 0, 0x020 for channel 1 and 0x200 for channel 2. Each transmit window starts 0x100 above its channel's receive window. Within every window the status register is at +0x0, the set register at +0x8 and the clear register at +0x10.
- R7: When a set and a clear hit the same word in the same cycle, from either port or both, the new word is (old & ~clear) | set. If a bit is both set and cleared, the set wins.
- R8: Reads of set or clear registers return zero. Writes to a status register are ignored. Reads of unmapped addresses return zero, and writes to unmapped addresses change nothing.
- R9: The addresses 0xFE0, 0xFE4 and 0xFE8 return bits 7:0, 15:8 and 23:16 of the parameter `ID_VALUE` in the low byte of the read data. The default value of `ID_VALUE` is 24'h3C5A91.
- R10: A write changes state only in the access phase, when psel, penable and pwrite are all high. A setup-only cycle changes nothing, and neither does a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_psel | input | 1 | Local port select |
| loc_penable | input | 1 | Local port access phase |
| loc_pwrite | input | 1 | Local port write strobe |
| loc_paddr | input | 12 | Local port byte address |
| loc_pwdata | input | 32 | Local port write data |
| loc_prdata | output | 32 | Local port read data |
| rem_psel | input | 1 | Remote port select |
| rem_penable | input | 1 | Remote port access phase |
| rem_pwrite | input | 1 | Remote port write strobe |
| rem_paddr | input | 12 | Remote port byte address |
| rem_pwdata | input | 32 | Remote port write data |
| rem_prdata | output | 32 | Remote port read data |
| loc_irq | output | 3 | Per-channel receive interrupt toward the local side |
| rem_irq | output | 3 | Per-channel receive interrupt toward the remote side |

## Verification
The assertions assume that each port follows the setup-then-access order, so a write is counted only when psel, penable and pwrite are all high together. They also assume reset is held from time zero. The bench drives every transfer as one setup cycle followed by one access cycle, and it changes inputs only just after a rising edge. The one exception is the deliberate setup-only cycle, which checks that nothing changes when penable stays low. Both ports are driven in the same cycle only in the directed case that exercises the set-wins-over-clear rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_CH   = 3;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int TX_SKIP  = 'h100;
  localparam int OFS_STAT = 'h0;
  localparam int OFS_SET  = 'h8;
  localparam int OFS_CLR  = 'h10;
  localparam int ID_ADDR0 = 'hFE0;
  localparam int CH_W     = $clog2(NUM_CH);

  typedef enum logic [1:0] {K_NONE, K_STAT, K_SET, K_CLR} kind_e;

  typedef struct packed {
    logic            hit;
    logic            tx;
    logic [CH_W-1:0] ch;
    kind_e           kind;
  } dec_t;

  function automatic int chan_base(input int c);
    case (c)
      0:       return 'h000;
      1:       return 'h020;
      default: return 'h200;
    endcase
  endfunction

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d = '{hit: 1'b0, tx: 1'b0, ch: '0, kind: K_NONE};
    for (int c = 0; c < NUM_CH; c++) begin
      for (int t = 0; t < 2; t++) begin
        int base;
        base = chan_base(c) + (t * TX_SKIP);
        if (int'(a) == base + OFS_STAT) d = '{1'b1, t[0], CH_W'(c), K_STAT};
        if (int'(a) == base + OFS_SET)  d = '{1'b1, t[0], CH_W'(c), K_SET};
        if (int'(a) == base + OFS_CLR)  d = '{1'b1, t[0], CH_W'(c), K_CLR};
      end
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] next_word(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] set_m,
                                                  input logic [DATA_W-1:0] clr_m);
    return (old & ~clr_m) | set_m;
  endfunction
endpackage

// File: rtl/mbx_word.sv
module mbx_word
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_a,
  input  logic [DATA_W-1:0] set_b,
  input  logic [DATA_W-1:0] clr_a,
  input  logic [DATA_W-1:0] clr_b,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] set_m, clr_m;
  assign set_m = set_a | set_b;
  assign clr_m = clr_a | clr_b;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= next_word(q, set_m, clr_m);
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter logic [23:0] ID_VALUE = 24'h3C5A91
) (
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [DATA_W-1:0]             pwdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rx_view,
  input  logic [NUM_CH-1:0][DATA_W-1:0] tx_view,
  output logic [NUM_CH-1:0][DATA_W-1:0] set_rx,
  output logic [NUM_CH-1:0][DATA_W-1:0] clr_rx,
  output logic [NUM_CH-1:0][DATA_W-1:0] set_tx,
  output logic [NUM_CH-1:0][DATA_W-1:0] clr_tx,
  output logic [DATA_W-1:0]             prdata
);
  dec_t dec;
  logic wr_go, rd_go;
  assign dec   = decode_addr(paddr);
  assign wr_go = psel & penable & pwrite;
  assign rd_go = psel & ~pwrite;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic here;
    assign here      = wr_go & dec.hit & (dec.ch == CH_W'(c));
    assign set_rx[c] = (here & ~dec.tx & (dec.kind == K_SET)) ? pwdata : '0;
    assign clr_rx[c] = (here & ~dec.tx & (dec.kind == K_CLR)) ? pwdata : '0;
    assign set_tx[c] = (here &  dec.tx & (dec.kind == K_SET)) ? pwdata : '0;
    assign clr_tx[c] = (here &  dec.tx & (dec.kind == K_CLR)) ? pwdata : '0;
  end

  always_comb begin
    prdata = '0;
    if (rd_go) begin
      if (dec.hit && dec.kind == K_STAT)
        prdata = dec.tx ? tx_view[dec.ch] : rx_view[dec.ch];
      else if (paddr == ADDR_W'(ID_ADDR0))
        prdata = DATA_W'(ID_VALUE[7:0]);
      else if (paddr == ADDR_W'(ID_ADDR0 + 4))
        prdata = DATA_W'(ID_VALUE[15:8]);
      else if (paddr == ADDR_W'(ID_ADDR0 + 8))
        prdata = DATA_W'(ID_VALUE[23:16]);
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter logic [23:0] ID_VALUE = 24'h3C5A91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_psel,
  input  logic              loc_penable,
  input  logic              loc_pwrite,
  input  logic [ADDR_W-1:0] loc_paddr,
  input  logic [DATA_W-1:0] loc_pwdata,
  output logic [DATA_W-1:0] loc_prdata,
  input  logic              rem_psel,
  input  logic              rem_penable,
  input  logic              rem_pwrite,
  input  logic [ADDR_W-1:0] rem_paddr,
  input  logic [DATA_W-1:0] rem_pwdata,
  output logic [DATA_W-1:0] rem_prdata,
  output logic [NUM_CH-1:0] loc_irq,
  output logic [NUM_CH-1:0] rem_irq
);
  // l2r: sent by local, received by remote; r2l: the reverse
  logic [NUM_CH-1:0][DATA_W-1:0] l2r_q, r2l_q;
  logic [NUM_CH-1:0][DATA_W-1:0] l_set_rx, l_clr_rx, l_set_tx, l_clr_tx;
  logic [NUM_CH-1:0][DATA_W-1:0] r_set_rx, r_clr_rx, r_set_tx, r_clr_tx;
  // named events for the checker
  logic [NUM_CH-1:0][DATA_W-1:0] l2r_set_ev, l2r_clr_ev, r2l_set_ev, r2l_clr_ev;

  mbx_port #(.ID_VALUE(ID_VALUE)) u_loc (
    .psel(loc_psel), .penable(loc_penable), .pwrite(loc_pwrite),
    .paddr(loc_paddr), .pwdata(loc_pwdata),
    .rx_view(r2l_q), .tx_view(l2r_q),
    .set_rx(l_set_rx), .clr_rx(l_clr_rx), .set_tx(l_set_tx), .clr_tx(l_clr_tx),
    .prdata(loc_prdata)
  );

  mbx_port #(.ID_VALUE(ID_VALUE)) u_rem (
    .psel(rem_psel), .penable(rem_penable), .pwrite(rem_pwrite),
    .paddr(rem_paddr), .pwdata(rem_pwdata),
    .rx_view(l2r_q), .tx_view(r2l_q),
    .set_rx(r_set_rx), .clr_rx(r_clr_rx), .set_tx(r_set_tx), .clr_tx(r_clr_tx),
    .prdata(rem_prdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign l2r_set_ev[c] = l_set_tx[c] | r_set_rx[c];
    assign l2r_clr_ev[c] = l_clr_tx[c] | r_clr_rx[c];
    assign r2l_set_ev[c] = r_set_tx[c] | l_set_rx[c];
    assign r2l_clr_ev[c] = r_clr_tx[c] | l_clr_rx[c];

    mbx_word u_l2r (
      .clk(clk), .rst_n(rst_n),
      .set_a(l_set_tx[c]), .set_b(r_set_rx[c]),
      .clr_a(l_clr_tx[c]), .clr_b(r_clr_rx[c]),
      .q(l2r_q[c])
    );

    mbx_word u_r2l (
      .clk(clk), .rst_n(rst_n),
      .set_a(r_set_tx[c]), .set_b(l_set_rx[c]),
      .clr_a(r_clr_tx[c]), .clr_b(l_clr_rx[c]),
      .q(r2l_q[c])
    );

    assign loc_irq[c] = |r2l_q[c];
    assign rem_irq[c] = |l2r_q[c];
  end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
  import mbx_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            loc_psel,
  input logic                            loc_penable,
  input logic                            loc_pwrite,
  input logic [ADDR_W-1:0]               loc_paddr,
  input logic [DATA_W-1:0]               loc_prdata,
  input logic                            rem_psel,
  input logic                            rem_penable,
  input logic                            rem_pwrite,
  input logic [NUM_CH-1:0]               loc_irq,
  input logic [NUM_CH-1:0]               rem_irq,
  input logic [NUM_CH-1:0][DATA_W-1:0]   l2r_q,
  input logic [NUM_CH-1:0][DATA_W-1:0]   r2l_q,
  input logic [NUM_CH-1:0][DATA_W-1:0]   l2r_set_ev,
  input logic [NUM_CH-1:0][DATA_W-1:0]   l2r_clr_ev,
  input logic [NUM_CH-1:0][DATA_W-1:0]   r2l_set_ev,
  input logic [NUM_CH-1:0][DATA_W-1:0]   r2l_clr_ev
);
  localparam int NW = 2 * NUM_CH;
  logic [NW-1:0][DATA_W-1:0] all_q, all_set, all_clr;
  logic any_write;
  assign all_q     = {l2r_q, r2l_q};
  assign all_set   = {l2r_set_ev, r2l_set_ev};
  assign all_clr   = {l2r_clr_ev, r2l_clr_ev};
  assign any_write = (loc_psel & loc_penable & loc_pwrite) |
                     (rem_psel & rem_penable & rem_pwrite);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (all_q == '0 && loc_irq == '0 && rem_irq == '0));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> $stable(all_q));

  assert_setclr_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_psel && !loc_pwrite && (loc_paddr == ADDR_W'(OFS_SET) ||
     loc_paddr == ADDR_W'(OFS_CLR))) |-> loc_prdata == '0);

  for (genvar w = 0; w < NW; w++) begin : g_w
    assert_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (all_clr[w] == '0) |=> ((($past(all_q[w]) & ~all_q[w])) == '0));

    assert_clear_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (all_set[w] == '0) |=>
        ((all_q[w] & $past(all_clr[w])) == '0 &&
         (all_q[w] & ~$past(all_clr[w])) == ($past(all_q[w]) & ~$past(all_clr[w]))));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (all_set[w] != '0) |=> ((all_q[w] & $past(all_set[w])) == $past(all_set[w])));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_irq[c] == (r2l_q[c] != '0)) && (rem_irq[c] == (l2r_q[c] != '0)));
  end
endmodule

bind mbx_doorbell mbx_doorbell_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .loc_psel(loc_psel), .loc_penable(loc_penable), .loc_pwrite(loc_pwrite),
  .loc_paddr(loc_paddr), .loc_prdata(loc_prdata),
  .rem_psel(rem_psel), .rem_penable(rem_penable), .rem_pwrite(rem_pwrite),
  .loc_irq(loc_irq), .rem_irq(rem_irq),
  .l2r_q(l2r_q), .r2l_q(r2l_q),
  .l2r_set_ev(l2r_set_ev), .l2r_clr_ev(l2r_clr_ev),
  .r2l_set_ev(r2l_set_ev), .r2l_clr_ev(r2l_clr_ev)
);

// File: tb/sim_mbx_doorbell.sv
module sim_mbx_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] ID = 24'h3C5A91;
  localparam int NV = 18;
  // {port(1: remote), write, addr[11:0], data[31:0], expected read[31:0]}
  localparam logic [77:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 12'h108, 32'h0000_0005, 32'h0},          // R2 local tx ch0 set
    {1'b1, 1'b0, 12'h000, 32'h0,         32'h0000_0005},  // R5 remote rx sees it
    {1'b0, 1'b0, 12'h100, 32'h0,         32'h0000_0005},  // R5 local tx view
    {1'b0, 1'b1, 12'h108, 32'h0000_0030, 32'h0},          // R2 OR in more
    {1'b1, 1'b0, 12'h000, 32'h0,         32'h0000_0035},  // R2
    {1'b1, 1'b1, 12'h010, 32'h0000_0014, 32'h0},          // R3 clear bits 2,4
    {1'b0, 1'b0, 12'h100, 32'h0,         32'h0000_0021},  // R3
    {1'b1, 1'b1, 12'h000, 32'h0000_FFFF, 32'h0},          // R8 status write
    {1'b1, 1'b0, 12'h000, 32'h0,         32'h0000_0021},  // R8 ignored
    {1'b1, 1'b0, 12'h008, 32'h0,         32'h0},          // R8 set reads 0
    {1'b1, 1'b0, 12'h010, 32'h0,         32'h0},          // R8 clear reads 0
    {1'b1, 1'b1, 12'h128, 32'hA000_0000, 32'h0},          // R6 remote tx ch1
    {1'b0, 1'b0, 12'h020, 32'h0,         32'hA000_0000},  // R6 local rx ch1
    {1'b0, 1'b1, 12'h308, 32'h0000_0001, 32'h0},          // R6 local tx ch2
    {1'b1, 1'b0, 12'h200, 32'h0,         32'h0000_0001},  // R6 remote rx ch2
    {1'b0, 1'b0, 12'h040, 32'h0,         32'h0},          // R8 unmapped
    {1'b0, 1'b0, 12'hFE0, 32'h0,         32'h0000_0091},  // R9 id byte0
    {1'b1, 1'b0, 12'hFE8, 32'h0,         32'h0000_003C}   // R9 id byte2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sel = 0, l_en = 0, l_wr = 0, r_sel = 0, r_en = 0, r_wr = 0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [31:0] l_wd = '0, r_wd = '0;
  logic [31:0] l_rd, r_rd;
  logic [2:0] l_irq, r_irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbx_doorbell u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_psel(l_sel), .loc_penable(l_en), .loc_pwrite(l_wr),
    .loc_paddr(l_addr), .loc_pwdata(l_wd), .loc_prdata(l_rd),
    .rem_psel(r_sel), .rem_penable(r_en), .rem_pwrite(r_wr),
    .rem_paddr(r_addr), .rem_pwdata(r_wd), .rem_prdata(r_rd),
    .loc_irq(l_irq), .rem_irq(r_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit port, input bit sel, input bit en, input bit wr,
                       input logic [11:0] a, input logic [31:0] d);
    if (port) begin r_sel = sel; r_en = en; r_wr = wr; r_addr = a; r_wd = d; end
    else      begin l_sel = sel; l_en = en; l_wr = wr; l_addr = a; l_wd = d; end
  endtask

  task automatic bus_wr(input bit port, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 drive(port, 1, 0, 1, a, d);
    @(posedge clk); #1 drive(port, 1, 1, 1, a, d);
    @(posedge clk); #1 drive(port, 0, 0, 0, a, 32'h0);
  endtask

  task automatic bus_rd(input bit port, input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1 drive(port, 1, 0, 0, a, 32'h0);
    @(posedge clk); #1 drive(port, 1, 1, 0, a, 32'h0);
    @(negedge clk); d = port ? r_rd : l_rd;
    @(posedge clk); #1 drive(port, 0, 0, 0, a, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 loc_irq", {29'h0, l_irq}, 32'h0);
    check("R1 rem_irq", {29'h0, r_irq}, 32'h0);
    bus_rd(0, 12'h100, rd); check("R1 word", rd, 32'h0);
    bus_rd(1, 12'h300, rd); check("R1 word", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      if (v[76]) bus_wr(v[77], v[75:64], v[63:32]);
      else begin
        bus_rd(v[77], v[75:64], rd);
        check($sformatf("vector %0d (R2/R3/R5/R6/R8/R9)", i), rd, v[31:0]);
      end
    end

    // R4 per-channel lines
    @(negedge clk);
    check("R4 loc_irq", {29'h0, l_irq}, 32'h2);
    check("R4 rem_irq", {29'h0, r_irq}, 32'h5);
    // R5 completion: remote clears all, local sees zero
    bus_wr(1, 12'h010, 32'h21);
    @(negedge clk);
    check("R4 rem_irq after clear", {29'h0, r_irq}, 32'h4);
    bus_rd(0, 12'h100, rd); check("R5 sender sees zero", rd, 32'h0);
    // R8 unmapped write changes nothing
    bus_wr(0, 12'h044, 32'hFFFF_FFFF);
    bus_rd(0, 12'h100, rd); check("R8 unmapped write", rd, 32'h0);
    bus_rd(1, 12'h100, rd); check("R8 unmapped write", rd, 32'h0);
    // R7 simultaneous set (local) and clear (remote)
    bus_wr(0, 12'h108, 32'h4);
    @(posedge clk); #1 drive(0, 1, 0, 1, 12'h108, 32'h1); drive(1, 1, 0, 1, 12'h010, 32'h5);
    @(posedge clk); #1 drive(0, 1, 1, 1, 12'h108, 32'h1); drive(1, 1, 1, 1, 12'h010, 32'h5);
    @(posedge clk); #1 drive(0, 0, 0, 0, 12'h0, 32'h0); drive(1, 0, 0, 0, 12'h0, 32'h0);
    bus_rd(1, 12'h000, rd); check("R7 set wins", rd, 32'h1);
    // R10 setup-only write has no effect
    @(posedge clk); #1 drive(0, 1, 0, 1, 12'h108, 32'hF0);
    @(posedge clk); #1 drive(0, 0, 0, 0, 12'h108, 32'h0);
    bus_rd(0, 12'h100, rd); check("R10 setup-only", rd, 32'h1);
    // R9 middle byte
    bus_rd(0, 12'hFE4, rd); check("R9 id byte1", rd, {24'h0, ID[15:8]});
    // R1 second reset clears pending words
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 re-reset loc_irq", {29'h0, l_irq}, 32'h0);
    check("R1 re-reset rem_irq", {29'h0, r_irq}, 32'h0);
    bus_rd(0, 12'h020, rd); check("R1 re-reset word", rd, 32'h0);
    finish_run();
  end
endmodule